// File: doc/BRIEF.md
# Transmit Frame Pad and FCS Inserter

This stage sits on the transmit path between the transmit FIFO and the media-side serializer. It passes a frame's payload bytes through unchanged. It then extends a short frame with zero bytes and appends the 32-bit Ethernet frame check sequence where that is required. Both sides carry the bytes as a valid/ready/last stream. Each frame brings two control flags with its first byte: one asks for the check sequence to be left off, and the other turns off short-frame padding.

The stage computes the CRC-32 on the fly over every byte it emits, including any pad bytes. Padding takes precedence over the flag that disables the check sequence: if a frame was extended, the four check bytes always follow, because a padded frame without a check sequence would be useless on the wire.

A frame has started once its first byte has been accepted. If the FIFO then runs dry while the downstream side is pulling, the stage ends the frame on its output with a single abort beat, which carries the underflow marker. It sends no check sequence for that frame. It then silently consumes the rest of the broken frame up to its last byte.

Top module: `tx_pad_fcs`

## Requirements
- R1: While a frame's payload is flowing, every input byte appears on the output unchanged and in order, and `in_ready` follows `out_ready`.
- R2: With `in_nopad` = 0, a frame of fewer than 60 payload bytes is followed by zero-valued pad bytes until 60 bytes have been sent.
- R3: A frame that was padded is always followed by 4 check bytes, even when `in_nocrc` = 1.
- R4: With `in_nocrc` = 1 and no padding (the frame has at least 60 payload bytes, or `in_nopad` = 1), the frame ends with `out_last` on its final payload byte.
- R5: With `in_nopad` = 1, no pad byte is ever inserted, whatever the frame length.
- R6: The check bytes are the bitwise inverse of the reflected CRC-32 (polynomial 0x04C11DB7, register preset to all ones), computed over the payload and pad bytes and sent least significant byte first. For the nine ASCII bytes "123456789" they are 0x26, 0x39, 0xF4, 0xCB.
- R7: The flags are taken from the first byte of each frame. Their values on later bytes of the same frame have no effect.
- R8: Once a frame has started, a cycle with `out_ready` = 1 and `in_valid` = 0 is an underflow. The next output beat is an abort beat: data 0x00, `out_last` = 1, `out_underflow` = 1. No check bytes follow it.
- R9: After an abort beat, the remaining input bytes of that frame, up to and including its last, are accepted and produce no output. The next frame is then handled normally.
- R10: While a pad, check or abort beat is stalled by `out_ready` = 0, `out_valid`, `out_data` and `out_last` hold their values and no input byte is accepted.
- R11: After reset, with no input offered, `out_valid` and `out_underflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Stage accepts the input byte |
| in_data | input | 8 | Payload byte from the FIFO |
| in_last | input | 1 | Final payload byte of the frame |
| in_nocrc | input | 1 | Leave off the check sequence (sampled on the first byte) |
| in_nopad | input | 1 | Disable short-frame padding (sampled on the first byte) |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final beat of the output frame |
| out_underflow | output | 1 | Marks the abort beat of an underflowed frame |

## Verification
The assertions assume two things about the upstream side. First, it holds a byte, its `in_last` and its flags steady until `in_ready` accepts it. Second, once a frame has started, it lets `in_valid` fall only when it really has run dry. Otherwise the hold and underflow properties would be judging stimulus rather than design. The bench driver keeps a beat unchanged until it is taken, and it offers the bytes of every random frame back to back. It drops `in_valid` mid-frame only in the directed underflow runs, and for those it forces the sink ready so that the gap lands on a pulling cycle. Random back-pressure is limited to `out_ready`, which by itself can never cause an underflow.

// File: rtl/txpc_pkg.sv
package txpc_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned FCS_W     = 32;
  localparam int unsigned FCS_BYTES = FCS_W / BYTE_W;

  // Phase of the stage within a frame
  typedef enum logic [2:0] {
    ST_DATA  = 3'd0,   // payload passthrough (or idle between frames)
    ST_PAD   = 3'd1,   // emitting zero pad bytes
    ST_FCS   = 3'd2,   // emitting the check sequence
    ST_ABORT = 3'd3,   // emitting the underflow abort beat
    ST_DRAIN = 3'd4    // discarding the rest of a broken frame
  } txpc_state_e;

  function automatic logic [FCS_W-1:0] mirror_word(input logic [FCS_W-1:0] v);
    logic [FCS_W-1:0] r;
    for (int i = 0; i < int'(FCS_W); i++) r[i] = v[FCS_W-1-i];
    return r;
  endfunction

  // One byte through the reflected CRC register, LSB of the byte first
  function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] c,
                                                input logic [BYTE_W-1:0] d,
                                                input logic [FCS_W-1:0] poly_rev);
    logic [FCS_W-1:0] r;
    r = c;
    for (int i = 0; i < int'(BYTE_W); i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ poly_rev;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/txpc_fcs.sv
module txpc_fcs
  import txpc_pkg::*;
#(
  parameter logic [FCS_W-1:0] POLY = 32'h04C11DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              restart,
  input  logic [BYTE_W-1:0] din,
  output logic [FCS_W-1:0]  fcs_o
);

  localparam logic [FCS_W-1:0] POLY_REV = mirror_word(POLY);

  logic [FCS_W-1:0] crc_q;
  logic [FCS_W-1:0] crc_d;
  logic [FCS_W-1:0] crc_base;

  always_comb begin
    crc_base = restart ? '1 : crc_q;
    crc_d    = fcs_step(crc_base, din, POLY_REV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= '1;
    else if (step_en) crc_q <= crc_d;
  end

  assign fcs_o = ~crc_q;

endmodule

// File: rtl/txpc_seq.sv
module txpc_seq
  import txpc_pkg::*;
#(
  parameter int unsigned MIN_BODY = 60
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic                         in_last,
  input  logic                         in_nocrc,
  input  logic                         in_nopad,
  input  logic                         out_ready,
  output txpc_state_e                  state_o,
  output logic [$clog2(FCS_BYTES)-1:0] idx_o,
  output logic                         first_o,
  output logic                         data_end_o,
  output logic                         fcs_end_o
);

  localparam int unsigned CNT_W = $clog2(MIN_BODY + 1);
  localparam int unsigned IDX_W = $clog2(FCS_BYTES);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(MIN_BODY);
  localparam logic [CNT_W-1:0] CNT_PADLO = CNT_W'(MIN_BODY - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FCS_BYTES - 1);

  txpc_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             cnt_en;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             nocrc_q, nopad_q, flag_en;
  logic             first, eff_nocrc, eff_nopad, need_pad, data_acc;

  // ---------------- next-state logic ----------------
  always_comb begin
    first     = (cnt_q == '0);
    eff_nocrc = first ? in_nocrc : nocrc_q;
    eff_nopad = first ? in_nopad : nopad_q;
    need_pad  = !eff_nopad && (cnt_q < CNT_PADLO);
    cnt_inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    data_acc  = in_valid && out_ready;

    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    flag_en = 1'b0;

    unique case (state_q)
      ST_DATA: begin
        if (data_acc) begin
          cnt_en  = 1'b1;
          cnt_d   = cnt_inc;
          flag_en = first;
          if (in_last) begin
            if (need_pad)        state_d = ST_PAD;
            else if (!eff_nocrc) state_d = ST_FCS;
            else                 cnt_d   = '0;
          end
        end else if (!first && !in_valid && out_ready) begin
          state_d = ST_ABORT;
          cnt_en  = 1'b1;
          cnt_d   = '0;
        end
      end
      ST_PAD: begin
        if (out_ready) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_inc;
          if (cnt_q == CNT_PADLO) state_d = ST_FCS;
        end
      end
      ST_FCS: begin
        if (out_ready) begin
          idx_en = 1'b1;
          if (idx_q == IDX_LAST) begin
            idx_d   = '0;
            state_d = ST_DATA;
            cnt_en  = 1'b1;
            cnt_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_ABORT: begin
        if (out_ready) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (in_valid && in_last) state_d = ST_DATA;
      end
      default: begin
        state_d = ST_DATA;
        cnt_en  = 1'b1;
        cnt_d   = '0;
      end
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_DATA;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nocrc_q <= 1'b0;
      nopad_q <= 1'b0;
    end else if (flag_en) begin
      nocrc_q <= in_nocrc;
      nopad_q <= in_nopad;
    end
  end

  assign state_o    = state_q;
  assign idx_o      = idx_q;
  assign first_o    = first;
  assign data_end_o = in_last && !need_pad && eff_nocrc;
  assign fcs_end_o  = (idx_q == IDX_LAST);

  // ---------------- assertions ----------------
  // R2: the pad phase never runs past the minimum body length
  a_r2_pad_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAD) |-> (cnt_q < CNT_MAX));

  // R3: leaving the pad phase always leads into the check sequence
  a_r3_pad_then_fcs: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_PAD && state_q != ST_PAD) |-> (state_q == ST_FCS));

  // R8: an abort is only entered after a starved, pulling cycle
  a_r8_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ABORT && $past(state_q) != ST_ABORT) |-> $past(!in_valid && out_ready));

endmodule

// File: rtl/tx_pad_fcs.sv
module tx_pad_fcs
  import txpc_pkg::*;
#(
  parameter int unsigned      MIN_BODY = 60,
  parameter logic [31:0]      POLY     = 32'h04C11DB7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_nocrc,
  input  logic       in_nopad,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       out_underflow
);

  localparam int unsigned IDX_W = $clog2(FCS_BYTES);

  txpc_state_e       state;
  logic [IDX_W-1:0]  fcs_idx;
  logic              frame_first;
  logic              data_end;
  logic              fcs_end;
  logic [FCS_W-1:0]  fcs_word;
  logic              fcs_step_en;
  logic              fcs_restart;
  logic [BYTE_W-1:0] fcs_din;

  txpc_seq #(.MIN_BODY(MIN_BODY)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_nocrc   (in_nocrc),
    .in_nopad   (in_nopad),
    .out_ready  (out_ready),
    .state_o    (state),
    .idx_o      (fcs_idx),
    .first_o    (frame_first),
    .data_end_o (data_end),
    .fcs_end_o  (fcs_end)
  );

  // CRC advances on every payload or pad byte that leaves the stage
  always_comb begin
    fcs_step_en = 1'b0;
    fcs_restart = 1'b0;
    fcs_din     = '0;
    if (state == ST_DATA) begin
      fcs_step_en = in_valid && out_ready;
      fcs_restart = frame_first;
      fcs_din     = in_data;
    end else if (state == ST_PAD) begin
      fcs_step_en = out_ready;
    end
  end

  txpc_fcs #(.POLY(POLY)) u_fcs (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (fcs_step_en),
    .restart (fcs_restart),
    .din     (fcs_din),
    .fcs_o   (fcs_word)
  );

  // Output selection by phase
  always_comb begin
    in_ready      = 1'b0;
    out_valid     = 1'b0;
    out_data      = '0;
    out_last      = 1'b0;
    out_underflow = 1'b0;
    unique case (state)
      ST_DATA: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
        out_last  = data_end;
      end
      ST_PAD: begin
        out_valid = 1'b1;
      end
      ST_FCS: begin
        out_valid = 1'b1;
        out_data  = fcs_word[BYTE_W*fcs_idx +: BYTE_W];
        out_last  = fcs_end;
      end
      ST_ABORT: begin
        out_valid     = 1'b1;
        out_last      = 1'b1;
        out_underflow = 1'b1;
      end
      ST_DRAIN: begin
        in_ready = 1'b1;
      end
      default: begin
        in_ready = 1'b0;
      end
    endcase
  end

  // R10: generated beats hold still under back-pressure
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_DATA && out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_last)));

  // R8: the underflow marker only rides on a closing beat
  a_r8_uf_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_underflow |-> (out_valid && out_last && out_data == 8'h00));

  // R9: nothing is emitted while the broken frame is drained
  a_r9_drain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_underflow && out_ready)) |-> !out_valid);

endmodule

// File: tb/tx_pad_fcs_test.sv
`timescale 1ns/1ps
module tx_pad_fcs_test;

  logic       clk;
  logic       rst_n;
  logic       in_valid, in_ready, in_last, in_nocrc, in_nopad;
  logic [7:0] in_data;
  logic       out_valid, out_ready, out_last, out_underflow;
  logic [7:0] out_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;
  int ready_pct = 100;

  logic [7:0] fbytes[$];
  logic [7:0] exp_q[$];
  logic [7:0] cur_q[$];
  logic [7:0] rx_frame[$];
  bit         rx_uf;
  int         rx_count = 0;
  bit         stall_prev = 0;
  logic [7:0] prev_data;
  logic       prev_last;

  tx_pad_fcs uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_nocrc(in_nocrc), .in_nopad(in_nopad),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_underflow(out_underflow)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;   // 200 MHz

  // Reference CRC: reflected CRC-32, preset ones, inverted result
  function automatic logic [31:0] ref_fcs(input logic [7:0] q[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (q[k]) begin
      c ^= {24'h0, q[k]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic void build_exp(input bit nocrc, input bit nopad);
    logic [31:0] f;
    bit padded;
    exp_q = fbytes;
    padded = 0;
    if (!nopad) while (exp_q.size() < 60) begin exp_q.push_back(8'h00); padded = 1; end
    if (padded || !nocrc) begin
      f = ref_fcs(exp_q);
      for (int k = 0; k < 4; k++) exp_q.push_back(f[8*k +: 8]);
    end
  endfunction

  // Sink: random back-pressure
  always @(posedge clk) begin
    #1;
    out_ready = (($urandom % 100) < ready_pct);
  end

  // Monitor, mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        checks++;
        if (!(out_valid && out_data == prev_data && out_last == prev_last)) begin
          fails++;
          $display("FAIL R10 stalled beat changed: valid=%0b data=%02h last=%0b expected valid=1 data=%02h last=%0b",
                   out_valid, out_data, out_last, prev_data, prev_last);
        end
      end
      stall_prev = out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
      if (out_valid && out_ready) begin
        cur_q.push_back(out_data);
        if (out_last) begin
          rx_frame = cur_q;
          rx_uf    = out_underflow;
          cur_q.delete();
          rx_count++;
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
      $finish;
    end
  end

  task automatic drive_frame(input bit nocrc, input bit nopad, input int gap_at);
    for (int i = 0; i < fbytes.size(); i++) begin
      if (i == gap_at) begin
        in_valid = 0;
        repeat (2) @(posedge clk);
        #1;
      end
      in_valid = 1;
      in_data  = fbytes[i];
      in_last  = (i == fbytes.size() - 1);
      in_nocrc = (i == 0) ? nocrc : 1'($urandom);
      in_nopad = (i == 0) ? nopad : 1'($urandom);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
    end
    in_valid = 0;
    in_last  = 0;
  endtask

  task automatic fill(input int len, input bit ascii);
    fbytes.delete();
    for (int i = 0; i < len; i++) fbytes.push_back(ascii ? 8'(8'h31 + i) : 8'($urandom));
  endtask

  task automatic compare(input string tag, input bit exp_uf);
    checks++;
    if (rx_frame.size() != exp_q.size() || rx_uf != exp_uf) begin
      fails++;
      $display("FAIL %s frame shape: len=%0d uf=%0b expected len=%0d uf=%0b",
               tag, rx_frame.size(), rx_uf, exp_q.size(), exp_uf);
      return;
    end
    foreach (exp_q[k]) if (rx_frame[k] != exp_q[k]) begin
      fails++;
      $display("FAIL %s byte %0d: got %02h expected %02h", tag, k, rx_frame[k], exp_q[k]);
      return;
    end
  endtask

  task automatic run_frame(input string tag, input int len, input bit nocrc, input bit nopad);
    int target;
    fill(len, 0);
    build_exp(nocrc, nopad);
    target = rx_count + 1;
    drive_frame(nocrc, nopad, -1);
    wait (rx_count >= target);
    @(posedge clk); #1;
    compare(tag, 0);
  endtask

  task automatic run_underflow(input int len, input int gap_at);
    int target;
    int pct_save;
    pct_save  = ready_pct;
    ready_pct = 100;
    @(posedge clk); #1;
    fill(len, 0);
    exp_q.delete();
    for (int k = 0; k < gap_at; k++) exp_q.push_back(fbytes[k]);
    exp_q.push_back(8'h00);
    target = rx_count + 1;
    drive_frame(0, 0, gap_at);
    wait (rx_count >= target);
    compare("R8 abort beat", 1);
    ready_pct = pct_save;
    // R9: drained bytes produce nothing; the next frame is intact
    target = rx_count + 1;
    run_frame("R9 frame after drain", 12, 0, 1);
    checks++;
    if (rx_count != target) begin
      fails++;
      $display("FAIL R9 frame count %0d expected %0d", rx_count, target);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; in_valid = 0; in_last = 0; in_data = 0; in_nocrc = 0; in_nopad = 0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_underflow !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset outputs valid=%0b uf=%0b expected 0 0", out_valid, out_underflow);
    end
    @(posedge clk); #1;

    // R6 known vector, no pad, with check bytes
    fill(9, 1);
    exp_q = fbytes;
    exp_q.push_back(8'h26); exp_q.push_back(8'h39); exp_q.push_back(8'hF4); exp_q.push_back(8'hCB);
    begin
      int target = rx_count + 1;
      drive_frame(0, 1, -1);
      wait (rx_count >= target);
      @(posedge clk); #1;
      compare("R6 known check value", 0);
    end

    run_frame("R2 R3 one byte padded, crc forced", 1, 1, 0);
    run_frame("R2 R3 59 bytes padded, crc forced", 59, 1, 0);
    run_frame("R4 60 bytes no pad no crc", 60, 1, 0);
    run_frame("R2 60 bytes no pad with crc", 60, 0, 0);
    run_frame("R5 short no pad no crc", 10, 1, 1);
    run_frame("R5 short no pad with crc", 10, 0, 1);
    run_frame("R4 one byte, no pad no crc", 1, 1, 1);

    ready_pct = 60;
    run_frame("R10 padded under back-pressure", 5, 0, 0);

    run_underflow(20, 1);
    run_underflow(80, 30);
    run_underflow(40, 39);

    for (int n = 0; n < 40; n++) begin
      ready_pct = 40 + ($urandom % 61);
      run_frame("R1 R7 random frame", 1 + ($urandom % 100), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule